// File: doc/BRIEF.md
# Two-Way Interleaved Bank Router

This block sits between a 32-bit processor request port and two memory banks, each a full data word wide. Every request carries a byte address, a write flag, four byte enables and write data. The block picks a bank from the parity of the double-word address, hands the request to that bank's port in the same cycle it is accepted, and starts a recovery timer for that bank. Until the timer runs out, a new request aimed at the same bank is held off by dropping `req_ready`. A request aimed at the other bank goes through at once. Because one bank recovers while the other works, a stream that alternates between banks runs at one request per clock. A stream that keeps hitting one bank runs at one request every `TPRE+1` clocks.

Reads return their data one cycle after acceptance, together with a one-cycle `rsp_valid` pulse. The data comes from whichever bank served the read, and responses appear in request order. Each bank port is a plain synchronous device: it samples the strobe, address, byte enables and data on a rising edge, and presents read data in the next cycle. Writes produce no response.

Two state machines make up the control. Each bank has a recovery FSM with states `BK_READY` and `BK_RECOVER`. It moves from `BK_READY` to `BK_RECOVER` on an access (when `TPRE` > 0). It moves from `BK_RECOVER` back to `BK_READY` once its down-counter reaches its last count. The response FSM has states `RS_IDLE` and `RS_RETURN`. It enters or stays in `RS_RETURN` whenever a read is accepted, and falls back to `RS_IDLE` in any cycle without a read acceptance.

Top module: `ilv_bank_steer`

## Requirements
- R1: Address bit 2 selects the bank: 0 (even double word) routes to bank 0, 1 (odd double word) routes to bank 1. In the cycle where `req_valid` and `req_ready` are both high, exactly the selected bank's `bankN_en` is high. At every other time both strobes are low.
- R2: While a bank strobe is high, that bank's address equals the request byte address with bits 2..0 removed (`req_addr[31:3]`).
- R3: The selected bank receives `req_be`, `req_wdata` and `req_write` unchanged, so any single byte of a double word can be written alone.
- R4: After a bank accepts an access, `req_ready` is low for any request targeting that bank during the next `TPRE` cycles. The earliest following accept to that bank is `TPRE+1` cycles after the previous one.
- R5: A recovering bank does not stall requests to the other bank. Alternating bank 0 / bank 1 requests are accepted on consecutive cycles with no wait, including a read accepted in the cycle its predecessor's data returns.
- R6: An accepted read raises `rsp_valid` for exactly the next cycle. `rsp_rdata` then holds the word the serving bank returns, and responses follow request order.
- R7: An accepted write produces no `rsp_valid` pulse.
- R8: After reset, `req_ready` is high for either bank, both bank strobes are low and `rsp_valid` is low.
- R9: Successive byte accesses inside one double word all hit the same bank, and each one waits out that bank's full `TPRE`-cycle recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte enables, bit i covers data byte i |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Target bank can accept this cycle |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| bank0_en | output | 1 | Bank 0 access strobe |
| bank0_we | output | 1 | Bank 0 write flag |
| bank0_addr | output | 29 | Bank 0 word address |
| bank0_be | output | 4 | Bank 0 byte enables |
| bank0_wdata | output | 32 | Bank 0 write data |
| bank0_rdata | input | 32 | Bank 0 read data, one cycle after strobe |
| bank1_en | output | 1 | Bank 1 access strobe |
| bank1_we | output | 1 | Bank 1 write flag |
| bank1_addr | output | 29 | Bank 1 word address |
| bank1_be | output | 4 | Bank 1 byte enables |
| bank1_wdata | output | 32 | Bank 1 write data |
| bank1_rdata | input | 32 | Bank 1 read data, one cycle after strobe |

## Verification
The bench counts the stall cycles of every request and compares them with a count derived from each bank's last accept.

- A timer that is one cycle short or one cycle long shifts that count. A bank that blocks the other bank turns an alternating stream's zero waits into nonzero ones.
- Four single-byte writes into one double word, followed by a read, catch byte-enable loss and mis-merged bytes. They also confirm that every one of those writes pays the full recovery.
- Reads that alternate banks back to back check that the response mux follows the bank that served the read, not the bank being accepted now.
- The top double word of the address space catches a bank address that was sliced at the wrong bit.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Per-bank recovery state
    typedef enum logic {
        BK_READY   = 1'b0,
        BK_RECOVER = 1'b1
    } bank_state_e;

    // Read-response state
    typedef enum logic {
        RS_IDLE   = 1'b0,
        RS_RETURN = 1'b1
    } rsp_state_e;

    // Counter width able to hold a count of n (at least one bit)
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ilv_bank_decode.sv
module ilv_bank_decode #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 2,
    localparam int unsigned BANK_AW = ADDR_W - OFF_W - 1
) (
    input  logic [ADDR_W-1:0]  byte_addr,
    output logic               bank_sel,
    output logic [BANK_AW-1:0] bank_word
);

    // The bit just above the byte offset is the double-word parity.
    always_comb begin
        bank_sel  = byte_addr[OFF_W];
        bank_word = byte_addr[ADDR_W-1:OFF_W+1];
    end

endmodule

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer
    import ilv_pkg::*;
#(
    parameter int unsigned TPRE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic busy
);

    localparam int unsigned CNT_W = cnt_width(TPRE);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TPRE);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BK_READY: begin
                if (fire && (TPRE != 0)) begin
                    state_d = BK_RECOVER;
                    cnt_d   = LOAD_VAL;
                end
            end
            BK_RECOVER: begin
                if (cnt_q == LAST_VAL) begin
                    state_d = BK_READY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - LAST_VAL;
                end
            end
            default: begin
                state_d = BK_READY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            BK_READY:   busy = 1'b0;
            BK_RECOVER: busy = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/ilv_resp_path.sv
module ilv_resp_path
    import ilv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic              fire_bank,
    input  logic [DATA_W-1:0] bank0_rdata,
    input  logic [DATA_W-1:0] bank1_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    rsp_state_e state_q, state_d;
    logic       src_q, src_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    // Next state: remember which bank serves the read in flight
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            RS_IDLE: begin
                if (rd_fire) begin
                    state_d = RS_RETURN;
                    src_d   = fire_bank;
                end
            end
            RS_RETURN: begin
                if (rd_fire) begin
                    state_d = RS_RETURN;
                    src_d   = fire_bank;
                end else begin
                    state_d = RS_IDLE;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            RS_IDLE: begin
                rsp_valid = 1'b0;
                rsp_rdata = '0;
            end
            RS_RETURN: begin
                rsp_valid = 1'b1;
                rsp_rdata = src_q ? bank1_rdata : bank0_rdata;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/ilv_bank_steer.sv
module ilv_bank_steer
    import ilv_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TPRE   = 3,
    localparam int unsigned BE_W    = DATA_W / 8,
    localparam int unsigned OFF_W   = $clog2(BE_W),
    localparam int unsigned BANK_AW = ADDR_W - OFF_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BE_W-1:0]    req_be,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               bank0_en,
    output logic               bank0_we,
    output logic [BANK_AW-1:0] bank0_addr,
    output logic [BE_W-1:0]    bank0_be,
    output logic [DATA_W-1:0]  bank0_wdata,
    input  logic [DATA_W-1:0]  bank0_rdata,
    output logic               bank1_en,
    output logic               bank1_we,
    output logic [BANK_AW-1:0] bank1_addr,
    output logic [BE_W-1:0]    bank1_be,
    output logic [DATA_W-1:0]  bank1_wdata,
    input  logic [DATA_W-1:0]  bank1_rdata
);

    localparam int unsigned NBANK = 2;

    logic               sel;
    logic [BANK_AW-1:0] word_addr;
    logic [NBANK-1:0]   busy;
    logic [NBANK-1:0]   fire;
    logic               accept;

    ilv_bank_decode #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_decode (
        .byte_addr (req_addr),
        .bank_sel  (sel),
        .bank_word (word_addr)
    );

    // The requested bank alone decides whether the request may go.
    always_comb begin
        req_ready = !busy[sel];
        accept    = req_valid && req_ready;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_comb fire[b] = accept && (sel == 1'(b));

        ilv_bank_timer #(
            .TPRE (TPRE)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (fire[b]),
            .busy  (busy[b])
        );
    end

    // Bank port fan-out: both banks see the payload, only one sees a strobe.
    always_comb begin
        bank0_en    = fire[0];
        bank0_we    = fire[0] && req_write;
        bank0_addr  = word_addr;
        bank0_be    = req_be;
        bank0_wdata = req_wdata;
        bank1_en    = fire[1];
        bank1_we    = fire[1] && req_write;
        bank1_addr  = word_addr;
        bank1_be    = req_be;
        bank1_wdata = req_wdata;
    end

    ilv_resp_path #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_fire     (accept && !req_write),
        .fire_bank   (sel),
        .bank0_rdata (bank0_rdata),
        .bank1_rdata (bank1_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

endmodule

// File: rtl/ilv_bank_steer_checker.sv
module ilv_bank_steer_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned BANK_AW = 29,
    parameter int unsigned TPRE    = 3,
    parameter int unsigned OFF_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               bank0_en,
    input logic [BANK_AW-1:0] bank0_addr,
    input logic               bank1_en,
    input logic [BANK_AW-1:0] bank1_addr
);

    localparam int unsigned CW = (TPRE < 1) ? 1 : $clog2(TPRE + 1);

    logic [CW-1:0] win0, win1;

    // Independent recovery windows seen from the bank strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win0 <= '0;
            win1 <= '0;
        end else begin
            win0 <= bank0_en ? CW'(TPRE) : ((win0 != 0) ? win0 - CW'(1) : win0);
            win1 <= bank1_en ? CW'(TPRE) : ((win1 != 0) ? win1 - CW'(1) : win1);
        end
    end

    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (bank0_en != bank1_en));

    assert_no_idle_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |-> (!bank0_en && !bank1_en));

    assert_bank_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bank1_en |-> req_addr[OFF_W]);

    assert_word_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bank0_en |-> (bank0_addr == req_addr[ADDR_W-1:OFF_W+1]));

    assert_recover0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win0 != 0) |-> !bank0_en);

    assert_recover1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win1 != 0) |-> !bank1_en);

    assert_rsp_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    assert_no_write_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !rsp_valid);

endmodule

bind ilv_bank_steer ilv_bank_steer_checker #(
    .ADDR_W  (ADDR_W),
    .BANK_AW (BANK_AW),
    .TPRE    (TPRE),
    .OFF_W   (OFF_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .bank0_en   (bank0_en),
    .bank0_addr (bank0_addr),
    .bank1_en   (bank1_en),
    .bank1_addr (bank1_addr)
);

// File: tb/ilv_bank_steer_bench.sv
`timescale 1ns/1ps
module ilv_bank_steer_bench;

    localparam int TPRE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        b0_en, b0_we, b1_en, b1_we;
    logic [28:0] b0_addr, b1_addr;
    logic [3:0]  b0_be, b1_be;
    logic [31:0] b0_wd, b1_wd;
    logic [31:0] b0_rd = '0, b1_rd = '0;

    always #2.5 clk = ~clk;

    ilv_bank_steer #(.TPRE(TPRE)) u_ilv_bank_steer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bank0_en(b0_en), .bank0_we(b0_we), .bank0_addr(b0_addr),
        .bank0_be(b0_be), .bank0_wdata(b0_wd), .bank0_rdata(b0_rd),
        .bank1_en(b1_en), .bank1_we(b1_we), .bank1_addr(b1_addr),
        .bank1_be(b1_be), .bank1_wdata(b1_wd), .bank1_rdata(b1_rd)
    );

    // Bank device models: 16 words each, one-cycle read latency
    logic [31:0] bm0 [16];
    logic [31:0] bm1 [16];
    initial begin
        for (int i = 0; i < 16; i++) begin bm0[i] = '0; bm1[i] = '0; end
    end
    always @(posedge clk) begin
        if (b0_en) begin
            if (b0_we) begin
                for (int k = 0; k < 4; k++)
                    if (b0_be[k]) bm0[b0_addr[3:0]][8*k +: 8] <= b0_wd[8*k +: 8];
            end else b0_rd <= bm0[b0_addr[3:0]];
        end
        if (b1_en) begin
            if (b1_we) begin
                for (int k = 0; k < 4; k++)
                    if (b1_be[k]) bm1[b1_addr[3:0]][8*k +: 8] <= b1_wd[8*k +: 8];
            end else b1_rd <= bm1[b1_addr[3:0]];
        end
    end

    int checks = 0, errors = 0;
    int cyc = 0;
    int last_acc [2] = '{-100, -100};
    logic [31:0] ref_mem [logic [31:0]];

    typedef struct { bit is_rd; logic [31:0] data; } item_t;
    item_t sb [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: present one request, check stall count and bank port, push expectation
    task automatic do_req(input bit wr, input logic [31:0] addr, input logic [3:0] be,
                          input logic [31:0] wd, input string tag);
        int waited = 0;
        int expw;
        int bk = int'(addr[2]);
        logic [31:0] key = {addr[31:2], 2'b00};
        logic [31:0] cur;
        item_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
        expw = last_acc[bk] + TPRE + 1 - (cyc + 1);
        if (expw < 0) expw = 0;
        #1;
        while (!req_ready && waited < 50) begin
            waited++;
            @(negedge clk); #1;
        end
        chk(waited == expw, tag, "stall cycles", waited, expw);
        // R1 R2 R3: strobe, word address and payload at the selected bank
        if (bk == 0) begin
            chk(b0_en && !b1_en, "R1", "bank0 strobe", {b1_en, b0_en}, 2'b01);
            chk(b0_addr == addr[31:3], "R2", "bank0 addr", b0_addr, addr[31:3]);
            chk(b0_we == wr && b0_be == be && b0_wd == wd, "R3", "bank0 payload", b0_be, be);
        end else begin
            chk(b1_en && !b0_en, "R1", "bank1 strobe", {b1_en, b0_en}, 2'b10);
            chk(b1_addr == addr[31:3], "R2", "bank1 addr", b1_addr, addr[31:3]);
            chk(b1_we == wr && b1_be == be && b1_wd == wd, "R3", "bank1 payload", b1_be, be);
        end
        @(posedge clk); #1;
        last_acc[bk] = cyc;
        req_valid = 1'b0;
        cur = ref_mem.exists(key) ? ref_mem[key] : 32'h0;
        if (wr) begin
            for (int k = 0; k < 4; k++) if (be[k]) cur[8*k +: 8] = wd[8*k +: 8];
            ref_mem[key] = cur;
        end
        it.is_rd = !wr; it.data = cur;
        sb.push_back(it);
    endtask

    // Monitor: the cycle after each accept must match the queued expectation
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                if (it.is_rd) begin
                    chk(rsp_valid, "R6", "read rsp_valid", rsp_valid, 1);
                    chk(rsp_rdata == it.data, "R6", "read data", rsp_rdata, it.data);
                end else begin
                    chk(!rsp_valid, "R7", "write rsp_valid", rsp_valid, 0);
                end
            end else if (rsp_valid) begin
                chk(1'b0, "R7", "unexpected rsp_valid", rsp_valid, 0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R8: reset state for both bank targets
        req_addr = 32'h0; #0.1;
        chk(req_ready, "R8", "ready bank0 after reset", req_ready, 1);
        req_addr = 32'h4; #0.1;
        chk(req_ready, "R8", "ready bank1 after reset", req_ready, 1);
        chk(!b0_en && !b1_en && !rsp_valid, "R8", "idle outputs", {b1_en, b0_en, rsp_valid}, 0);

        // R5 R1: alternating full-word writes, no stalls
        do_req(1, 32'h00, 4'hF, 32'h1111_0000, "R5");
        do_req(1, 32'h04, 4'hF, 32'h2222_0004, "R5");
        do_req(1, 32'h08, 4'hF, 32'h3333_0008, "R5");
        do_req(1, 32'h0C, 4'hF, 32'h4444_000C, "R5");
        // R4: back-to-back to bank 0 must wait
        do_req(0, 32'h00, 4'hF, 32'h0, "R4");
        do_req(0, 32'h08, 4'hF, 32'h0, "R4");
        // R5 R6: alternating reads, each returning while the next is accepted
        do_req(0, 32'h0C, 4'hF, 32'h0, "R5");
        do_req(0, 32'h10, 4'hF, 32'h0, "R5");
        do_req(0, 32'h04, 4'hF, 32'h0, "R5");
        // R9 R3: byte writes into one double word, each pays full recovery
        do_req(1, 32'h10, 4'h1, 32'hAAAA_AA11, "R9");
        do_req(1, 32'h11, 4'h2, 32'hBBBB_22BB, "R9");
        do_req(1, 32'h12, 4'h4, 32'hCC33_CCCC, "R9");
        do_req(1, 32'h13, 4'h8, 32'h44DD_DDDD, "R9");
        do_req(0, 32'h10, 4'hF, 32'h0, "R9");
        // R2: top of address space on bank 1
        do_req(1, 32'hFFFF_FFFC, 4'hF, 32'hDEAD_BEEF, "R2");
        do_req(0, 32'hFFFF_FFFC, 4'hF, 32'h0, "R2");
        // R4: a request arriving after the window has elapsed does not wait
        repeat (TPRE + 2) @(negedge clk);
        do_req(0, 32'h0C, 4'hF, 32'h0, "R4");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule